// File: doc/BRIEF.md
# Joint-Table Colour Label Classifier

This block sorts a stream of RGB565 camera pixels into up to four tracked colours. A pixel arrives with a valid strobe, typically on every second clock. Adders alone turn it into one luminance value and two colour-difference values. Each colour-difference value is paired with a few luminance bits to address its own 512-entry table of 4-bit words. Bit i of a table word says whether colour i is accepted for that chrominance and brightness combination. The table contents therefore hold both the colour box and the brightness normalisation, so no divider is needed in the datapath.

The top luminance bit does not take up table space. Tracked colours are always brighter than half scale, so this bit gates the label directly. The label for each colour is the AND of the two table bits and this gate. A host port loads the tables while the system is being tuned. The label comes out of a register with its own valid flag, two register stages after the input strobe.

Top module: `colour_label_classifier`

## Requirements
- R1: With r = pix[15:11], g = pix[10:5], b = pix[4:0] and h = g[5:1], the block forms U = r − h and V = b − h as 7-bit two's complement values, and Y = r + h + b as a 7-bit unsigned value.
- R2: The colour-difference table entry is read at address {U[6:1], Y[5:3]}. The second table entry is read at address {V[6:1], Y[5:3]}.
- R3: Label bit i is the AND of bit i of the first table entry, bit i of the second table entry and Y[6].
- R4: A pixel with Y[6] = 0 (Y below 64) gives an all-zero label, whatever the table contents.
- R5: A pixel sampled with pix_vld_i high at clock edge k gives lbl_vld_o high for exactly the cycle after edge k+1. lbl_vld_o is low in every other cycle.
- R6: A host write samples host_tbl_sel_i (0 = first table, 1 = second table), host_addr_i and host_data_i when host_we_i is high, and replaces that one word. Pixels sampled at that same edge or later see the new word.
- R7: lbl_o holds its value in every cycle in which lbl_vld_o is low.
- R8: While rst_n is low, lbl_vld_o and lbl_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld_i | input | 1 | Pixel strobe |
| pix_i | input | 16 | RGB565 pixel |
| host_we_i | input | 1 | Table write enable |
| host_tbl_sel_i | input | 1 | Table select: 0 = first, 1 = second |
| host_addr_i | input | 9 | Table word address |
| host_data_i | input | 4 | Table word, one bit per colour |
| lbl_vld_o | output | 1 | Label valid |
| lbl_o | output | 4 | Colour label, one bit per colour |

## Verification
Assertions check the following on every cycle:
- The valid pulse timing.
- That the label holds between results.
- That a dark pixel gives an all-zero label.
- That a host write lands in the addressed word.
- That luminance never falls below either colour-difference value.

Only the bench scenarios can show the rest. These are the exact table addresses formed from each pixel, the AND of the two table words, and writes taking effect in the right cycle relative to the pixel stream. The bench checks them against a behavioural model for bright and dark pixels, negative colour differences, rewritten table words and back-to-back pixels.

// File: rtl/colour_cls_pkg.sv
package colour_cls_pkg;
  parameter int LBL_W   = 4;              // colours tracked in parallel
  parameter int CMP_W   = 7;              // width of U, V, Y
  parameter int CH_BITS = 6;              // chrominance bits per address
  parameter int LY_BITS = 3;              // luminance bits per address
  localparam int AW     = CH_BITS + LY_BITS;
  localparam int DEPTH  = 1 << AW;
  localparam int N_TBL  = 2;

  typedef struct packed {
    logic          vld;
    logic          gate;
    logic [AW-1:0] addr_u;
    logic [AW-1:0] addr_v;
  } lookup_req_t;
endpackage

// File: rtl/cc_yuv_xform.sv
module cc_yuv_xform
  import colour_cls_pkg::*;
(
  input  logic [15:0]      pix_i,
  output logic [CMP_W-1:0] u_o,
  output logic [CMP_W-1:0] v_o,
  output logic [CMP_W-1:0] y_o
);
  logic [CMP_W-1:0] r_ext, h_ext, b_ext, rb_sum;

  always_comb begin
    r_ext  = CMP_W'(pix_i[15:11]);
    h_ext  = CMP_W'(pix_i[10:6]);
    b_ext  = CMP_W'(pix_i[4:0]);
    u_o    = r_ext - h_ext;           // adder 1
    v_o    = b_ext - h_ext;           // adder 2
    rb_sum = r_ext + b_ext;           // adder 3
    y_o    = rb_sum + h_ext;          // adder 4
  end

  // R1: luminance is never below either signed colour difference
  always_comb begin
    a_r1_y_ge_u: assert ($signed({1'b0, y_o}) >= $signed({u_o[CMP_W-1], u_o}));
    a_r1_y_ge_v: assert ($signed({1'b0, y_o}) >= $signed({v_o[CMP_W-1], v_o}));
  end
endmodule

// File: rtl/cc_addr_stage.sv
module cc_addr_stage
  import colour_cls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld_i,
  input  logic [CMP_W-1:0] u_i,
  input  logic [CMP_W-1:0] v_i,
  input  logic [CMP_W-1:0] y_i,
  output lookup_req_t      req_o
);
  lookup_req_t req_d, req_q;
  logic        load_en;

  always_comb begin
    load_en       = pix_vld_i;
    req_d         = req_q;
    req_d.vld     = pix_vld_i;
    if (load_en) begin
      req_d.gate   = y_i[CMP_W-1];
      req_d.addr_u = {u_i[CMP_W-1 -: CH_BITS], y_i[CMP_W-2 -: LY_BITS]};
      req_d.addr_v = {v_i[CMP_W-1 -: CH_BITS], y_i[CMP_W-2 -: LY_BITS]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/cc_chroma_tbl.sv
module cc_chroma_tbl
  import colour_cls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LBL_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [LBL_W-1:0] rdata_o
);
  logic [LBL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  // R6: a written word is present the cycle after the write
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/colour_label_classifier.sv
module colour_label_classifier
  import colour_cls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld_i,
  input  logic [15:0]      pix_i,
  input  logic             host_we_i,
  input  logic             host_tbl_sel_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [LBL_W-1:0] host_data_i,
  output logic             lbl_vld_o,
  output logic [LBL_W-1:0] lbl_o
);
  logic [CMP_W-1:0] u_c, v_c, y_c;
  lookup_req_t      req;
  logic [AW-1:0]    rd_addr [N_TBL];
  logic [LBL_W-1:0] rd_data [N_TBL];
  logic [LBL_W-1:0] lbl_d, lbl_q;
  logic             vld_d, vld_q;

  cc_yuv_xform u_xform (.pix_i(pix_i), .u_o(u_c), .v_o(v_c), .y_o(y_c));

  cc_addr_stage u_addr (
    .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld_i),
    .u_i(u_c), .v_i(v_c), .y_i(y_c), .req_o(req)
  );

  assign rd_addr[0] = req.addr_u;
  assign rd_addr[1] = req.addr_v;

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    cc_chroma_tbl u_tbl (
      .clk(clk), .rst_n(rst_n),
      .we_i(host_we_i && (host_tbl_sel_i == 1'(t))),
      .waddr_i(host_addr_i), .wdata_i(host_data_i),
      .raddr_i(rd_addr[t]), .rdata_o(rd_data[t])
    );
  end

  always_comb begin
    vld_d = req.vld;
    lbl_d = lbl_q;
    if (req.vld) lbl_d = rd_data[0] & rd_data[1] & {LBL_W{req.gate}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lbl_q <= '0;
    end else begin
      vld_q <= vld_d;
      lbl_q <= lbl_d;
    end
  end

  assign lbl_vld_o = vld_q;
  assign lbl_o     = lbl_q;

  a_r5_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req.vld |=> lbl_vld_o);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req.vld |=> !lbl_vld_o);
  a_r7_label_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lbl_vld_o |-> $stable(lbl_o));
  a_r4_dark_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req.vld && !req.gate) |=> lbl_o == '0);
endmodule

// File: tb/sim_colour_label_classifier.sv
module sim_colour_label_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_vld_i = 1'b0;
  logic [15:0] pix_i = '0;
  logic       host_we_i = 1'b0;
  logic       host_tbl_sel_i = 1'b0;
  logic [8:0] host_addr_i = '0;
  logic [3:0] host_data_i = '0;
  logic       lbl_vld_o;
  logic [3:0] lbl_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc = 0;
  bit checking = 0;
  bit done = 0;
  int mu [512];
  int mv [512];
  int due_q [$];
  int lbl_qq [$];
  int held = 0;

  always #2.5 clk = ~clk;

  colour_label_classifier u0 (
    .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld_i), .pix_i(pix_i),
    .host_we_i(host_we_i), .host_tbl_sel_i(host_tbl_sel_i),
    .host_addr_i(host_addr_i), .host_data_i(host_data_i),
    .lbl_vld_o(lbl_vld_o), .lbl_o(lbl_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural model of R1-style transform, R2 addressing, R3/R4 combination
  function automatic int model_label(input int pix);
    int r, h, b, u, v, y, au, av, gate;
    r = (pix >> 11) & 31;
    h = (pix >> 6) & 31;
    b = pix & 31;
    u = (r - h) & 127;
    v = (b - h) & 127;
    y = r + h + b;
    au = ((u >> 1) << 3) | ((y >> 3) & 7);
    av = ((v >> 1) << 3) | ((y >> 3) & 7);
    gate = (y >= 64) ? 15 : 0;
    return mu[au] & mv[av] & gate;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      check(lbl_vld_o == 1'b0, "R8 valid in reset", int'(lbl_vld_o), 0);
      check(lbl_o == 4'd0, "R8 label in reset", int'(lbl_o), 0);
    end else if (checking) begin
      bit exp_v;
      exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
      if (exp_v) begin
        void'(due_q.pop_front());
        held = lbl_qq.pop_front();
      end
      check(lbl_vld_o == exp_v, "R5 valid timing", int'(lbl_vld_o), int'(exp_v));
      check(int'(lbl_o) == held, exp_v ? "R3 label value" : "R7 label hold",
            int'(lbl_o), held);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input int pix);
    pix_vld_i = 1'b1;
    pix_i = 16'(pix);
    due_q.push_back(cyc + 2);
    lbl_qq.push_back(model_label(pix));
    step();
    pix_vld_i = 1'b0;
  endtask

  task automatic hwrite(input int sel, input int addr, input int data);
    host_we_i = 1'b1;
    host_tbl_sel_i = 1'(sel);
    host_addr_i = 9'(addr);
    host_data_i = 4'(data);
    if (sel == 0) mu[addr] = data; else mv[addr] = data;
    step();
    host_we_i = 1'b0;
  endtask

  function automatic int mk(input int r, input int g, input int b);
    return (r << 11) | (g << 5) | b;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_fails++; n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R6: load both tables with a computed pattern
    for (int a = 0; a < 512; a++) hwrite(0, a, (a * 7 + 3) & 15);
    for (int a = 0; a < 512; a++) hwrite(1, a, ((a * 5) ^ (a >> 3)) & 15);
    step();
    checking = 1;
    // R1/R2/R3: white pixel, U=V=0, Y=93 -> addresses 3 and 3
    hwrite(0, 3, 4'b1010);
    hwrite(1, 3, 4'b0110);
    send(mk(31, 63, 31)); step();
    step(); step();
    check(lbl_o == 4'b0010, "R3 white pixel", int'(lbl_o), 2);
    // R6: rewrite second table word, same pixel
    hwrite(1, 3, 4'b1111);
    send(mk(31, 63, 31)); step();
    step(); step();
    check(lbl_o == 4'b1010, "R6 rewritten word", int'(lbl_o), 10);
    // R1/R2: negative V: r=31 h=20 b=15 -> U addr 40, V addr 488, Y=66
    hwrite(0, 40, 4'b1101);
    hwrite(1, 488, 4'b0111);
    send(mk(31, 40, 15)); step();
    step(); step();
    check(lbl_o == 4'b0101, "R2 negative difference", int'(lbl_o), 5);
    // R4: dark pixel, all table words one
    hwrite(0, 7, 15);
    hwrite(1, 7, 15);
    send(mk(20, 40, 20)); step();
    step(); step();
    check(lbl_o == 4'b0000, "R4 dark pixel", int'(lbl_o), 0);
    // R6: write in the same cycle as the pixel strobe
    host_we_i = 1'b1; host_tbl_sel_i = 1'b0; host_addr_i = 9'd3; host_data_i = 4'b0001;
    mu[3] = 1;
    send(mk(31, 63, 31));
    host_we_i = 1'b0;
    step(); step();
    // strobe every second clock, varied pixels
    for (int i = 0; i < 400; i++) begin
      send((i * 40503 + 12345) & 16'hffff);
      step();
    end
    // R5: back-to-back pixels
    for (int i = 0; i < 60; i++) send((i * 2654435 + 777) & 16'hffff);
    repeat (5) step();
    // R8: reset again mid-run
    checking = 0;
    rst_n = 1'b0;
    due_q.delete(); lbl_qq.delete(); held = 0;
    step(); step();
    rst_n = 1'b1;
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule